// File: doc/BRIEF.md
# Mode-Aware Address Decoder

This block sits between a 32-bit CPU bus and the memories and peripheral cores of a small secure controller. It routes each request by the top address byte to one of nine regions. Before it raises any select it checks the request against an execution-mode input. In firmware mode every mapped region is open. In application mode the firmware-private RAM, the device-secret store and a small window of memory-protection control registers are closed.

A request that is closed, or that falls on an unmapped prefix, reaches no target. No write strobe is forwarded for it, and it reads back as zero. The block still answers it with the same one-cycle ready pulse as an allowed access, so the CPU never waits. A denied flag comes back alongside that pulse.

Selects and the forwarded write strobe are combinational, in the cycle the request is taken. Targets are expected to present read data in the following cycle, which is the cycle in which ready is high.

Top module: `mode_addr_decoder`

## Requirements
- R1: In firmware mode (`fw_mode`=1) an accepted request raises exactly one bit of `tgt_sel` in the same cycle, chosen by `req_addr[31:24]`. The mapping is 0x00→bit0 (boot ROM), 0x40→bit1 (main RAM), 0xc0→bit2 (entropy source), 0xc1→bit3 (timer), 0xc2→bit4 (device secret), 0xc3→bit5 (serial port), 0xc4→bit6 (touch), 0xd0→bit7 (firmware RAM) and 0xff→bit8 (system control).
- R2: `tgt_sel` never has more than one bit set, and it is all zero whenever no request is accepted.
- R3: A top byte that matches none of the nine prefixes raises no select and no write strobe. It is answered with ready and denied both high, and `req_rdata` reads as 32'h0.
- R4: In application mode (`fw_mode`=0) an access to prefix 0xd0 raises no select, is denied, and reads as zero.
- R5: In application mode an access to prefix 0xc2 raises no select, is denied, and reads as 32'h0.
- R6: In application mode an access to prefix 0xff whose low 24 address bits fall in [PROT_LO, PROT_LO+PROT_BYTES) is denied and raises no select. The defaults are 0x60 and 8 bytes. Other 0xff offsets select bit8 in either mode.
- R7: `req_ready` is high in the cycle after each accepted request and is never high two cycles in a row. A request is accepted when `req_valid` is high and `req_ready` is low, so a valid held through its ready cycle is not taken twice.
- R8: For an allowed read, `req_rdata` in the ready cycle equals the 32-bit slice of `tgt_rdata` that belongs to the selected region (slice i = bits i*32+31..i*32).
- R9: In application mode, prefixes 0x00, 0x40, 0xc0, 0xc1, 0xc3 and 0xc4 select exactly as in firmware mode.
- R10: `tgt_we` is high only in the cycle of an allowed, accepted write. Allowed writes, as well as all blocked accesses, read as 32'h0 and leave `req_denied` low for an allowed write.
- R11: During and right after reset, `req_ready`, `req_denied` and `req_rdata` are zero, and `tgt_sel` is zero while `req_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fw_mode | input | 1 | 1 = firmware mode, 0 = application mode |
| req_valid | input | 1 | CPU request valid |
| req_we | input | 1 | CPU request is a write |
| req_addr | input | 32 | CPU byte address |
| req_ready | output | 1 | One-cycle acknowledge, one cycle after acceptance |
| req_denied | output | 1 | Request was blocked or unmapped (valid with ready) |
| req_rdata | output | DW | Read data to CPU, zero unless an allowed read |
| tgt_sel | output | 9 | One-hot region select |
| tgt_we | output | 1 | Write strobe forwarded to the selected region |
| tgt_rdata | input | 9*DW | Read data of all regions, region i in slice i |

## Verification
The hardest case to reach is a CPU that holds `req_valid` high through the ready cycle. A bench that pulses valid for one cycle would never expose a second, duplicate acceptance. A dedicated scenario therefore holds valid for several cycles and checks that ready alternates, with a select only in the non-ready cycles. The protection window also needs attention: its two edges, and the offsets just outside them, are driven in both modes so that an off-by-one in the window compare changes a select.

// File: rtl/mode_addr_decoder.sv
module mode_addr_decoder #(
  parameter int          DW         = 32,
  parameter logic [23:0] PROT_LO    = 24'h000060,
  parameter int          PROT_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fw_mode,
  input  logic            req_valid,
  input  logic            req_we,
  input  logic [31:0]     req_addr,
  output logic            req_ready,
  output logic            req_denied,
  output logic [DW-1:0]   req_rdata,
  output logic [8:0]      tgt_sel,
  output logic            tgt_we,
  input  logic [9*DW-1:0] tgt_rdata
);

  localparam int NREG = 9;
  localparam int SEC  = 4;
  localparam int FWR  = 7;
  localparam int SYS  = 8;
  localparam logic [24:0] WIN_LO = {1'b0, PROT_LO};
  localparam logic [24:0] WIN_HI = WIN_LO + 25'(PROT_BYTES);

  function automatic logic [7:0] prefix(input int i);
    case (i)
      0: prefix = 8'h00;
      1: prefix = 8'h40;
      2: prefix = 8'hc0;
      3: prefix = 8'hc1;
      4: prefix = 8'hc2;
      5: prefix = 8'hc3;
      6: prefix = 8'hc4;
      7: prefix = 8'hd0;
      default: prefix = 8'hff;
    endcase
  endfunction

  logic [NREG-1:0] hit, idx_q;
  logic            rdy_q, den_q, rd_q;
  logic            mapped, in_prot, blocked, allow, accept;
  logic [24:0]     ofs;

  always_comb begin
    for (int i = 0; i < NREG; i++) hit[i] = (req_addr[31:24] == prefix(i));
  end

  assign ofs     = {1'b0, req_addr[23:0]};
  assign mapped  = |hit;
  assign in_prot = hit[SYS] && (ofs >= WIN_LO) && (ofs < WIN_HI);
  assign blocked = !fw_mode && (hit[FWR] || hit[SEC] || in_prot);
  assign allow   = mapped && !blocked;
  assign accept  = req_valid && !rdy_q;

  assign tgt_sel = (accept && allow) ? hit : '0;
  assign tgt_we  = accept && allow && req_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      den_q <= 1'b0;
      rd_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      rdy_q <= accept;
      den_q <= accept && !allow;
      rd_q  <= accept && allow && !req_we;
      if (accept) idx_q <= hit;
    end
  end

  always_comb begin
    req_rdata = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_q && idx_q[i]) req_rdata = req_rdata | tgt_rdata[i*DW +: DW];
  end

  assign req_ready  = rdy_q;
  assign req_denied = den_q;

  a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));
  a_r2_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> tgt_sel == '0);
  a_r7_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_ready);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
  a_r3_denied_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_denied) |-> req_rdata == '0);
  a_r4_fwram_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw_mode && req_addr[31:24] == 8'hd0) |-> !tgt_sel[FWR]);
  a_r5_secret_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw_mode && req_addr[31:24] == 8'hc2) |-> !tgt_sel[SEC]);
  a_r10_we_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_we |-> (tgt_sel != '0 && req_we));

endmodule

// File: tb/test_mode_addr_decoder.sv
module test_mode_addr_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            fw_mode = 1;
  logic            req_valid = 0;
  logic            req_we = 0;
  logic [31:0]     req_addr = '0;
  logic            req_ready, req_denied, tgt_we;
  logic [DW-1:0]   req_rdata;
  logic [8:0]      tgt_sel;
  logic [9*DW-1:0] tgt_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mode_addr_decoder i_mode_addr_decoder (
    .clk(clk), .rst_n(rst_n), .fw_mode(fw_mode), .req_valid(req_valid),
    .req_we(req_we), .req_addr(req_addr), .req_ready(req_ready),
    .req_denied(req_denied), .req_rdata(req_rdata), .tgt_sel(tgt_sel),
    .tgt_we(tgt_we), .tgt_rdata(tgt_rdata)
  );

  function automatic logic [31:0] tval(input int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0101;
  endfunction

  initial for (int i = 0; i < 9; i++) tgt_rdata[i*DW +: DW] = tval(i);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request: exp_idx < 0 means no select expected
  task automatic access(input string req, input logic mode, input logic we,
                        input logic [31:0] addr, input int exp_idx, input logic exp_den);
    logic [8:0] es;
    logic [31:0] er;
    es = (exp_idx < 0) ? 9'h0 : 9'(1 << exp_idx);
    er = (exp_idx >= 0 && !we) ? tval(exp_idx) : 32'h0;
    @(negedge clk);
    fw_mode = mode; req_we = we; req_addr = addr; req_valid = 1;
    #1;
    check({req, " sel"}, 32'(tgt_sel), 32'(es));
    check({req, " we"}, 32'(tgt_we), 32'(we && exp_idx >= 0));
    check({req, " no early ready"}, 32'(req_ready), 32'h0);
    @(negedge clk);
    check({req, " ready"}, 32'(req_ready), 32'h1);
    check({req, " denied"}, 32'(req_denied), 32'(exp_den));
    check({req, " rdata"}, req_rdata, er);
    req_valid = 0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R11 ready in reset", 32'(req_ready), 0);
    check("R11 denied in reset", 32'(req_denied), 0);
    check("R11 rdata in reset", req_rdata, 0);
    check("R11 sel idle", 32'(tgt_sel), 0);
    rst_n = 1;
    @(negedge clk);
    check("R11 ready after reset", 32'(req_ready), 0);
  endtask

  task automatic t_fw_map;
    logic [7:0] pf [9] = '{8'h00, 8'h40, 8'hc0, 8'hc1, 8'hc2, 8'hc3, 8'hc4, 8'hd0, 8'hff};
    for (int i = 0; i < 9; i++)
      access("R1 R8 fw read", 1, 0, {pf[i], 24'h000010 + 24'(i*4)}, i, 0);
    access("R10 fw write ram", 1, 1, 32'h4000_0100, 1, 0);
    access("R10 fw write fwram", 1, 1, 32'hd000_0004, 7, 0);
  endtask

  task automatic t_unmapped;
    access("R3 unmapped 0x80", 1, 0, 32'h8000_0000, -1, 1);
    access("R3 unmapped 0xc5", 1, 1, 32'hc500_0000, -1, 1);
    access("R3 unmapped app", 0, 0, 32'hfe00_0000, -1, 1);
  endtask

  task automatic t_app_blocked;
    access("R4 app read fwram", 0, 0, 32'hd000_0020, -1, 1);
    access("R4 app write fwram", 0, 1, 32'hd000_0020, -1, 1);
    access("R5 app read secret", 0, 0, 32'hc200_0000, -1, 1);
    access("R5 app write secret", 0, 1, 32'hc200_0008, -1, 1);
  endtask

  task automatic t_prot_window;
    access("R6 app prot low edge", 0, 0, 32'hff00_0060, -1, 1);
    access("R6 app prot high edge", 0, 1, 32'hff00_0067, -1, 1);
    access("R6 app below window", 0, 0, 32'hff00_005f, 8, 0);
    access("R6 app above window", 0, 0, 32'hff00_0068, 8, 0);
    access("R6 fw in window", 1, 1, 32'hff00_0064, 8, 0);
  endtask

  task automatic t_app_open;
    logic [7:0] pf [6] = '{8'h00, 8'h40, 8'hc0, 8'hc1, 8'hc3, 8'hc4};
    int ix [6] = '{0, 1, 2, 3, 5, 6};
    for (int i = 0; i < 6; i++)
      access("R9 app open read", 0, 0, {pf[i], 24'h000200}, ix[i], 0);
    access("R9 R10 app write uart", 0, 1, 32'hc300_0004, 5, 0);
  endtask

  task automatic t_held_valid;
    @(negedge clk);
    fw_mode = 1; req_we = 0; req_addr = 32'hc100_0000; req_valid = 1;
    #1;
    check("R7 held: first accept sel", 32'(tgt_sel), 32'h8);
    @(negedge clk); #1;
    check("R7 held: ready cycle1", 32'(req_ready), 1);
    check("R7 held: no sel in ready cycle", 32'(tgt_sel), 0);
    @(negedge clk); #1;
    check("R7 held: ready drops", 32'(req_ready), 0);
    check("R7 held: second accept sel", 32'(tgt_sel), 32'h8);
    @(negedge clk); #1;
    check("R7 held: ready again", 32'(req_ready), 1);
    check("R8 held: rdata", req_rdata, tval(3));
    req_valid = 0;
    @(negedge clk);
    check("R7 no ready after drop", 32'(req_ready), 0);
    check("R2 idle no sel", 32'(tgt_sel), 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_fw_map();
    t_unmapped();
    t_app_blocked();
    t_prot_window();
    t_app_open();
    t_held_valid();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule